// File: doc/BRIEF.md
# Page-Mode DRAM Controller with Open-Row Tracking

This block drives fast page mode DRAM for a 16-bit embedded processor with a pipelined bus. Each access is announced by a one-cycle address strobe carrying a word address, two byte enables, a write flag and a flag that says the address was issued early in pipelined fashion. The controller splits the address into row, column and bank according to the installed memory size. It places row and column in turn on an 11-bit multiplexed address bus, and drives one row strobe, four column strobes (two byte lanes for each of two banks) and a write enable. When an access completes, it reports how many wait states the access needs, so that a separate ready generator can end the bus cycle.

The row strobe is shared by both banks, so a row stays open across the whole memory. A tag register holds the open row. A pipelined access to that row runs its column cycle on the very next clock. An access that misses pays for a precharge and a new row strobe. Periodic refresh uses the column-before-row order. It closes the page, it waits for an access in flight to finish, and it defers any access that arrives while it runs.

States: `ST_IDLE` (row closed), `ST_OPEN` (row open, waiting), `ST_PRE` (precharge on a miss), `ST_ROW` (row strobe), `ST_CSET` (column setup for a hit that was not pipelined), `ST_COL` (column strobe, access done), `ST_RPRE` (precharge before refresh), `ST_CBR_CAS`, `ST_CBR_RAS`, `ST_CBR_END` (refresh steps).

Transitions:
- `ST_IDLE` goes to `ST_CBR_CAS` when refresh is pending, otherwise to `ST_ROW` on a request.
- `ST_OPEN` goes to `ST_RPRE` when refresh is pending. On a request it goes to `ST_COL` (pipelined hit), to `ST_CSET` (hit that was not pipelined) or to `ST_PRE` (miss).
- The access path runs `ST_PRE`→`ST_ROW`→`ST_COL`, and `ST_CSET`→`ST_COL`. `ST_COL` returns to `ST_OPEN`.
- The refresh path runs `ST_RPRE`→`ST_CBR_CAS`→`ST_CBR_RAS`→`ST_CBR_END`→`ST_IDLE`.

Top module: `pmdram_ctrl`

## Requirements
- R1: After reset `ras_n`, `we_n` and all four `cas_n` bits are high, `acc_done` and `wait_vld` are low, `mem_addr` is zero, and no row is open.
- R2: With size code s on `cfg_size` (0..4 for 1, 2, 4, 8, 16 MB; values above 4 act as 4), the column is the low 9+floor(s/2) bits of the word address, the row is the next 9+s-floor(s/2) bits, and the bank is the single bit above the row. `mem_addr` carries the row during the row-strobe cycle and the column during the column cycle.
- R3: A pipelined access to the open row reports 0 wait states, and `acc_done` rises in the first cycle after acceptance.
- R4: An access to the open row that was not pipelined reports 1 wait state and completes in the second cycle after acceptance.
- R5: An access while no row is open reports 1 wait state: a row-strobe cycle, then the column cycle.
- R6: An access to a row other than the open one reports 2 wait states. `ras_n` is high for exactly the first cycle after acceptance, then the new row is strobed, then the column.
- R7: After a miss, the tag register holds the new row, so the next access to that row is a hit.
- R8: In the column cycle, `cas_n[2*b+l]` is low exactly for bank b and each byte lane l (0 = low byte, 1 = high byte) whose enable bit `cpu_be[l]` is set.
- R9: `we_n` is low only in the column cycle of a write, and high for reads.
- R10: On refresh all four `cas_n` go low one cycle before `ras_n` falls. Both stay low for one cycle, then all strobes go high, with `mem_addr` at zero throughout. A closed row starts this two cycles after the `ref_req` pulse; an open row first gets one precharge cycle.
- R11: Refresh closes the page, so the first access after it reports 1 wait state even for the previous row.
- R12: Refresh waits for an access in flight. An access strobed while refresh is pending or running is held and is run after refresh ends.
- R13: `wait_vld` pulses in the first cycle after an access is accepted, with `wait_cnt` at that access's wait-state count (never above 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_size | input | 3 | Installed memory size code |
| cpu_addr | input | 23 | Word address from the CPU |
| cpu_be | input | 2 | Byte enables, bit 0 low byte, bit 1 high byte |
| cpu_ads | input | 1 | One-cycle address strobe |
| cpu_pipe | input | 1 | Address was issued pipelined |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| ref_req | input | 1 | Refresh request pulse |
| mem_addr | output | 11 | Multiplexed row/column address |
| ras_n | output | 1 | Row strobe, shared by both banks |
| cas_n | output | 4 | Column strobes {bank1 high, bank1 low, bank0 high, bank0 low} |
| we_n | output | 1 | DRAM write enable |
| acc_done | output | 1 | High in the column cycle of an access |
| wait_vld | output | 1 | Wait-state report valid |
| wait_cnt | output | 2 | Wait states needed by the accepted access |

## Verification
The bench builds the block with its default widths: a 23-bit word address and an 11-bit multiplexed bus. It then steps through every size code, including an out-of-range code. This brings the narrowest 9/9 split and the widest 11/11 split within reach, along with the bank bit moving from address bit 18 to bit 22. Random addresses reuse the previous row half the time, so hits, misses, bank changes and lane patterns all occur at every size. Refresh is interleaved with both open and closed rows, and an access is strobed in the middle of a refresh.

// File: rtl/pmdram_pkg.sv
package pmdram_pkg;

    localparam int unsigned NBANK  = 2;
    localparam int unsigned LANES  = 2;
    localparam int unsigned CAS_W  = NBANK * LANES;
    localparam logic [2:0]  SZ_TOP = 3'd4;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_OPEN,
        ST_PRE,
        ST_ROW,
        ST_CSET,
        ST_COL,
        ST_RPRE,
        ST_CBR_CAS,
        ST_CBR_RAS,
        ST_CBR_END
    } dr_state_e;

    function automatic logic [2:0] clamp_size(input logic [2:0] sz);
        return (sz > SZ_TOP) ? SZ_TOP : sz;
    endfunction

    function automatic logic [4:0] col_bits(input logic [2:0] sz, input logic [4:0] base);
        logic [2:0] s;
        s = clamp_size(sz);
        return base + {3'b000, s[2:1]};
    endfunction

    function automatic logic [4:0] row_bits(input logic [2:0] sz, input logic [4:0] base);
        logic [2:0] s;
        s = clamp_size(sz);
        return base + {2'b00, s} - {3'b000, s[2:1]};
    endfunction

endpackage

// File: rtl/pmdram_addr_split.sv
module pmdram_addr_split
    import pmdram_pkg::*;
#(
    parameter int unsigned AW   = 23,
    parameter int unsigned MA_W = 11
) (
    input  logic [AW-1:0]   addr,
    input  logic [2:0]      size,
    output logic [MA_W-1:0] row,
    output logic [MA_W-1:0] col,
    output logic            bank
);

    localparam logic [4:0] BASE_W = 5'(MA_W - 2);

    logic [4:0]      cw;
    logic [4:0]      rw;
    logic [AW-1:0]   above;
    logic [MA_W-1:0] ones;

    always_comb begin
        cw    = col_bits(size, BASE_W);
        rw    = row_bits(size, BASE_W);
        ones  = '1;
        above = addr >> cw;
        col   = addr[MA_W-1:0] & ~(ones << cw);
        row   = above[MA_W-1:0] & ~(ones << rw);
        bank  = |(above & (AW'(1) << rw));
    end

endmodule

// File: rtl/pmdram_page_tag.sv
module pmdram_page_tag #(
    parameter int unsigned MA_W = 11
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            clear,
    input  logic [MA_W-1:0] load_row,
    input  logic [MA_W-1:0] cmp_row,
    output logic            hit
);

    logic            tag_vld;
    logic [MA_W-1:0] tag_row;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_vld <= 1'b0;
            tag_row <= '0;
        end else if (clear) begin
            tag_vld <= 1'b0;
        end else if (load) begin
            tag_vld <= 1'b1;
            tag_row <= load_row;
        end
    end

    assign hit = tag_vld && (tag_row == cmp_row);

    // R11: a refresh closes the page, so nothing can hit right after it
    p_clear_miss_r11: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !hit);

endmodule

// File: rtl/pmdram_fsm.sv
module pmdram_fsm
    import pmdram_pkg::*;
#(
    parameter int unsigned MA_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             req_pipe,
    input  logic             hit,
    input  logic             ref_pend,
    input  logic [MA_W-1:0]  acc_row,
    input  logic [MA_W-1:0]  acc_col,
    input  logic             acc_bank,
    input  logic [LANES-1:0] acc_be,
    input  logic             acc_wr,
    output logic             accept,
    output logic             ref_go,
    output logic             page_load,
    output logic [MA_W-1:0]  mem_addr,
    output logic             ras_n,
    output logic [CAS_W-1:0] cas_n,
    output logic             we_n,
    output logic             acc_done,
    output logic             wait_vld,
    output logic [1:0]       wait_cnt
);

    dr_state_e state;
    dr_state_e nxt;
    logic      can_go;
    logic      cas_col;
    logic      cas_ref;
    logic [1:0] wait_next;

    assign can_go = (state == ST_IDLE) || (state == ST_OPEN);
    assign ref_go = can_go && ref_pend;
    assign accept = can_go && !ref_pend && req;

    always_comb begin
        if (state == ST_IDLE) begin
            wait_next = 2'd1;
        end else if (hit) begin
            wait_next = req_pipe ? 2'd0 : 2'd1;
        end else begin
            wait_next = 2'd2;
        end
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (ref_pend)  nxt = ST_CBR_CAS;
                else if (req)  nxt = ST_ROW;
            end
            ST_OPEN: begin
                if (ref_pend)  nxt = ST_RPRE;
                else if (req)  nxt = hit ? (req_pipe ? ST_COL : ST_CSET) : ST_PRE;
            end
            ST_PRE:     nxt = ST_ROW;
            ST_ROW:     nxt = ST_COL;
            ST_CSET:    nxt = ST_COL;
            ST_COL:     nxt = ST_OPEN;
            ST_RPRE:    nxt = ST_CBR_CAS;
            ST_CBR_CAS: nxt = ST_CBR_RAS;
            ST_CBR_RAS: nxt = ST_CBR_END;
            ST_CBR_END: nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    // state register and wait report
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            wait_vld <= 1'b0;
            wait_cnt <= 2'd0;
        end else begin
            state    <= nxt;
            wait_vld <= accept;
            if (accept) wait_cnt <= wait_next;
        end
    end

    // output decode
    always_comb begin
        ras_n     = 1'b1;
        we_n      = 1'b1;
        mem_addr  = '0;
        acc_done  = 1'b0;
        cas_col   = 1'b0;
        cas_ref   = 1'b0;
        page_load = 1'b0;
        unique case (state)
            ST_IDLE, ST_PRE, ST_RPRE, ST_CBR_END: begin
            end
            ST_OPEN: ras_n = 1'b0;
            ST_ROW: begin
                ras_n     = 1'b0;
                mem_addr  = acc_row;
                page_load = 1'b1;
            end
            ST_CSET: begin
                ras_n    = 1'b0;
                mem_addr = acc_col;
            end
            ST_COL: begin
                ras_n    = 1'b0;
                mem_addr = acc_col;
                cas_col  = 1'b1;
                we_n     = !acc_wr;
                acc_done = 1'b1;
            end
            ST_CBR_CAS: cas_ref = 1'b1;
            ST_CBR_RAS: begin
                cas_ref = 1'b1;
                ras_n   = 1'b0;
            end
            default: begin
            end
        endcase
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            assign cas_n[b*LANES+l] = !(cas_ref ||
                (cas_col && (acc_bank == 1'(b)) && acc_be[l]));
        end
    end

    // R10: when the row strobe falls with every column strobe low, they were already low
    p_cbr_order_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n && $past(ras_n) && (cas_n == '0)) |-> ($past(cas_n) == '0));

    // R13 / R6: the reported count never exceeds two
    p_wait_bound_r13: assert property (@(posedge clk) disable iff (!rst_n)
        wait_vld |-> (wait_cnt <= 2'd2));

    // R3: a pipelined hit finishes on the next cycle
    p_pipe_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (state == ST_OPEN) && hit && req_pipe) |=> acc_done);

    // R8: an access drives at most one bank's lanes
    p_lane_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n && (cas_n != '0)) |-> ($countones(~cas_n) <= LANES));

    // R12: refresh starting means no access completes next cycle
    p_holdoff_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ref_go |=> !acc_done);

    // R9: write enable only together with a column strobe
    p_we_with_cas_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> (cas_n != '1));

endmodule

// File: rtl/pmdram_ctrl.sv
module pmdram_ctrl
    import pmdram_pkg::*;
#(
    parameter int unsigned AW   = 23,
    parameter int unsigned MA_W = 11
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [2:0]      cfg_size,
    input  logic [AW-1:0]   cpu_addr,
    input  logic [1:0]      cpu_be,
    input  logic            cpu_ads,
    input  logic            cpu_pipe,
    input  logic            cpu_wr,
    input  logic            ref_req,
    output logic [MA_W-1:0] mem_addr,
    output logic            ras_n,
    output logic [3:0]      cas_n,
    output logic            we_n,
    output logic            acc_done,
    output logic            wait_vld,
    output logic [1:0]      wait_cnt
);

    logic            hold_vld;
    logic [AW-1:0]   hold_addr;
    logic [1:0]      hold_be;
    logic            hold_pipe;
    logic            hold_wr;
    logic            ref_pend;

    logic [AW-1:0]   src_addr;
    logic [1:0]      src_be;
    logic            src_pipe;
    logic            src_wr;
    logic            req;

    logic [MA_W-1:0] src_row;
    logic [MA_W-1:0] src_col;
    logic            src_bank;

    logic [MA_W-1:0] acc_row;
    logic [MA_W-1:0] acc_col;
    logic            acc_bank;
    logic [1:0]      acc_be;
    logic            acc_wr;

    logic            hit;
    logic            accept;
    logic            ref_go;
    logic            page_load;

    assign req      = cpu_ads || hold_vld;
    assign src_addr = hold_vld ? hold_addr : cpu_addr;
    assign src_be   = hold_vld ? hold_be   : cpu_be;
    assign src_pipe = hold_vld ? hold_pipe : cpu_pipe;
    assign src_wr   = hold_vld ? hold_wr   : cpu_wr;

    pmdram_addr_split #(.AW(AW), .MA_W(MA_W)) u_split (
        .addr (src_addr),
        .size (cfg_size),
        .row  (src_row),
        .col  (src_col),
        .bank (src_bank)
    );

    pmdram_page_tag #(.MA_W(MA_W)) u_tag (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (page_load),
        .clear    (ref_go),
        .load_row (acc_row),
        .cmp_row  (src_row),
        .hit      (hit)
    );

    pmdram_fsm #(.MA_W(MA_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .req_pipe  (src_pipe),
        .hit       (hit),
        .ref_pend  (ref_pend),
        .acc_row   (acc_row),
        .acc_col   (acc_col),
        .acc_bank  (acc_bank),
        .acc_be    (acc_be),
        .acc_wr    (acc_wr),
        .accept    (accept),
        .ref_go    (ref_go),
        .page_load (page_load),
        .mem_addr  (mem_addr),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .we_n      (we_n),
        .acc_done  (acc_done),
        .wait_vld  (wait_vld),
        .wait_cnt  (wait_cnt)
    );

    // deferred request and refresh pending flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_vld  <= 1'b0;
            hold_addr <= '0;
            hold_be   <= '0;
            hold_pipe <= 1'b0;
            hold_wr   <= 1'b0;
            ref_pend  <= 1'b0;
        end else begin
            ref_pend <= (ref_pend && !ref_go) || ref_req;
            if (accept && hold_vld) begin
                hold_vld <= 1'b0;
            end else if (cpu_ads && !accept) begin
                hold_vld  <= 1'b1;
                hold_addr <= cpu_addr;
                hold_be   <= cpu_be;
                hold_pipe <= cpu_pipe;
                hold_wr   <= cpu_wr;
            end
        end
    end

    // fields of the access being run
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_row  <= '0;
            acc_col  <= '0;
            acc_bank <= 1'b0;
            acc_be   <= '0;
            acc_wr   <= 1'b0;
        end else if (accept) begin
            acc_row  <= src_row;
            acc_col  <= src_col;
            acc_bank <= src_bank;
            acc_be   <= src_be;
            acc_wr   <= src_wr;
        end
    end

    // R12: a held request is served once the controller accepts again
    p_hold_served_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && hold_vld) |=> (wait_vld && !hold_vld));

endmodule

// File: tb/pmdram_ctrl_bench.sv
module pmdram_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int AW   = 23;
    localparam int MA_W = 11;

    logic            clk;
    logic            rst_n;
    logic [2:0]      cfg_size;
    logic [AW-1:0]   cpu_addr;
    logic [1:0]      cpu_be;
    logic            cpu_ads;
    logic            cpu_pipe;
    logic            cpu_wr;
    logic            ref_req;
    logic [MA_W-1:0] mem_addr;
    logic            ras_n;
    logic [3:0]      cas_n;
    logic            we_n;
    logic            acc_done;
    logic            wait_vld;
    logic [1:0]      wait_cnt;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  finished = 0;

    bit              m_open = 0;
    logic [MA_W-1:0] m_row  = '0;

    pmdram_ctrl #(.AW(AW), .MA_W(MA_W)) u_pmdram_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_size(cfg_size), .cpu_addr(cpu_addr),
        .cpu_be(cpu_be), .cpu_ads(cpu_ads), .cpu_pipe(cpu_pipe), .cpu_wr(cpu_wr),
        .ref_req(ref_req), .mem_addr(mem_addr), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .acc_done(acc_done), .wait_vld(wait_vld), .wait_cnt(wait_cnt)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    // expected address split, from the size table of R2
    function automatic int f_cw(input logic [2:0] sz);
        int s = (sz > 3'd4) ? 4 : int'(sz);
        return 9 + s / 2;
    endfunction
    function automatic int f_rw(input logic [2:0] sz);
        int s = (sz > 3'd4) ? 4 : int'(sz);
        return 9 + s - s / 2;
    endfunction
    function automatic logic [MA_W-1:0] f_col(input logic [AW-1:0] a, input logic [2:0] sz);
        return MA_W'(a & ((AW'(1) << f_cw(sz)) - 1));
    endfunction
    function automatic logic [MA_W-1:0] f_row(input logic [AW-1:0] a, input logic [2:0] sz);
        return MA_W'((a >> f_cw(sz)) & ((AW'(1) << f_rw(sz)) - 1));
    endfunction
    function automatic logic f_bank(input logic [AW-1:0] a, input logic [2:0] sz);
        return a[f_cw(sz) + f_rw(sz)];
    endfunction
    function automatic logic [3:0] f_cas(input logic bank, input logic [1:0] be);
        logic [3:0] c = 4'hF;
        if (be[0]) c[{bank, 1'b0}] = 1'b0;
        if (be[1]) c[{bank, 1'b1}] = 1'b0;
        return c;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one access, starting and ending at a falling edge
    task automatic do_access(input logic [AW-1:0] a, input logic [1:0] be,
                             input logic wr, input logic pipe);
        logic [MA_W-1:0] row = f_row(a, cfg_size);
        logic [MA_W-1:0] col = f_col(a, cfg_size);
        bit  hit  = m_open && (row == m_row);
        int  expw = !m_open ? 1 : (hit ? (pipe ? 0 : 1) : 2);
        bit  seen = 0;
        cpu_addr = a; cpu_be = be; cpu_wr = wr; cpu_pipe = pipe; cpu_ads = 1'b1;
        for (int k = 1; k <= 8 && !seen; k++) begin
            @(posedge clk); @(negedge clk);
            if (k == 1) begin
                cpu_ads = 1'b0;
                chk("R13 wait_vld", 32'(wait_vld), 32'd1);
                if (expw == 0)      chk("R3 wait_cnt", 32'(wait_cnt), 32'(expw));
                else if (!m_open)   chk("R5 wait_cnt", 32'(wait_cnt), 32'(expw));
                else if (expw == 1) chk("R4 wait_cnt", 32'(wait_cnt), 32'(expw));
                else                chk("R6 wait_cnt", 32'(wait_cnt), 32'(expw));
                if (expw == 2) chk("R6 precharge ras_n", 32'(ras_n), 32'd1);
            end
            if ((expw == 2 || !m_open) && k == expw) begin
                chk("R2 row ras_n", 32'(ras_n), 32'd0);
                chk("R2 row address", 32'(mem_addr), 32'(row));
            end
            if (acc_done) begin
                seen = 1;
                chk("R3 R4 R5 R6 done cycle", 32'(k), 32'(expw + 1));
                chk("R2 column address", 32'(mem_addr), 32'(col));
                chk("R8 lanes", 32'(cas_n), 32'(f_cas(f_bank(a, cfg_size), be)));
                chk("R9 we_n", 32'(we_n), 32'(!wr));
            end
        end
        if (!seen) chk("R3 R4 R5 R6 done seen", 32'(0), 32'(1));
        m_open = 1; m_row = row;
        @(posedge clk); @(negedge clk);
    endtask

    task automatic do_refresh();
        int o = m_open ? 1 : 0;
        ref_req = 1'b1;
        for (int k = 1; k <= 5 + o; k++) begin
            @(posedge clk); @(negedge clk);
            ref_req = 1'b0;
            if (k == 2 + o) begin
                chk("R10 cas first", 32'(cas_n), 32'h0);
                chk("R10 ras still high", 32'(ras_n), 32'd1);
            end
            if (k == 3 + o) begin
                chk("R10 both low", 32'({ras_n, cas_n}), 32'h0);
                chk("R10 no address", 32'(mem_addr), 32'h0);
            end
            if (k == 4 + o) chk("R10 release", 32'({ras_n, cas_n}), 32'h1F);
        end
        m_open = 0;
    endtask

    // access strobed while refresh is pending
    task automatic do_held(input logic [AW-1:0] a);
        int cbr_k = 0, done_k = 0;
        ref_req = 1'b1;
        @(posedge clk); @(negedge clk);
        ref_req = 1'b0;
        cpu_addr = a; cpu_be = 2'b11; cpu_wr = 1'b0; cpu_pipe = 1'b1; cpu_ads = 1'b1;
        for (int k = 2; k <= 20 && done_k == 0; k++) begin
            @(posedge clk); @(negedge clk);
            cpu_ads = 1'b0;
            if (cbr_k == 0 && cas_n == 4'h0 && ras_n) cbr_k = k;
            if (wait_vld) chk("R12 R11 held wait", 32'(wait_cnt), 32'd1);
            if (acc_done) done_k = k;
        end
        chk("R12 run after refresh", 32'(done_k), 32'(cbr_k + 5));
        m_open = 1; m_row = f_row(a, cfg_size);
        @(posedge clk); @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] a, last;
        logic [AW-1:0] cmask;
        logic [2:0] sizes [6] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd7};
        int r;
        r = int'($urandom(32'd7321));
        rst_n = 1'b0; cfg_size = 3'd4; cpu_addr = '0; cpu_be = 2'b00;
        cpu_ads = 1'b0; cpu_pipe = 1'b0; cpu_wr = 1'b0; ref_req = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        // R1 reset state
        chk("R1 ras_n", 32'(ras_n), 32'd1);
        chk("R1 cas_n", 32'(cas_n), 32'hF);
        chk("R1 we_n", 32'(we_n), 32'd1);
        chk("R1 done/wait", 32'({acc_done, wait_vld}), 32'd0);
        chk("R1 mem_addr", 32'(mem_addr), 32'd0);

        // directed corners at 16 MB
        a = 23'h12_3456;
        do_access(a, 2'b01, 1'b0, 1'b1);                   // R5 closed miss
        do_access(a ^ 23'h0_00F0, 2'b10, 1'b1, 1'b1);      // R3 and R7 hit
        do_access(a ^ 23'h0_0003, 2'b11, 1'b0, 1'b0);      // R4
        do_access(a ^ 23'h0_4000, 2'b10, 1'b1, 1'b1);      // R6 miss
        do_access(23'h40_0123, 2'b10, 1'b1, 1'b1);         // R8 bank 1 high lane
        do_refresh();                                      // R10 open row
        do_access(23'h40_0124, 2'b01, 1'b0, 1'b1);         // R11 same row is a miss
        do_held(23'h40_0200);                              // R12
        do_refresh();
        do_refresh();                                      // R10 closed row

        foreach (sizes[i]) begin
            cfg_size = sizes[i];
            cmask = (AW'(1) << f_cw(cfg_size)) - 1;
            last = AW'($urandom);
            for (int n = 0; n < 40; n++) begin
                if ($urandom_range(0, 1) == 1) a = (last & ~cmask) | (AW'($urandom) & cmask);
                else a = AW'($urandom);
                if ($urandom_range(0, 3) == 0) a = a ^ (AW'(1) << (f_cw(cfg_size) + f_rw(cfg_size)));
                do_access(a, 2'($urandom_range(1, 3)), 1'($urandom), 1'($urandom));
                last = a;
                if ($urandom_range(0, 15) == 0) do_refresh();
            end
            do_refresh();
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule